// File: doc/BRIEF.md
# Expansion Card Auto-Configuration Responder

This block gives a 64 KB expansion card its plug-and-play identity and its place in the host address map. After reset the card sits in a fixed configuration slot. A read at an even offset below 0x80 returns one nibble of the card's identity in the upper half of the data byte. A read at any other offset in the slot goes to the card's local register map, which is decoded the same way at the configuration slot as at the final base.

The host places the card in two steps. A write to offset 0x4A stores the low four bits of the new slot number, and may be repeated. A write to offset 0x48 supplies the upper four bits. That write commits the slot, and the card leaves the configuration slot for its new one. Instead of placing the card, the host may write offset 0x4C. The card then goes silent until the next reset.

All outputs are registered. They follow the bus strobe by one clock.

Top module: `xcard_autocfg`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge. After reset the card is unconfigured and responds at slot `CFG_SLOT`.
- R2: An unconfigured card takes a read (`bus_rd`=1, `bus_wr`=0) in slot `CFG_SLOT` at an even offset below 0x80. One clock later it sets `id_valid`=1 and `rdata` = {nibble, 4'h0}. Offset bits [6:2] select an identity byte. Offset bit 1 selects the half: 0 gives bits [7:4] and 1 gives bits [3:0].
- R3: The identity bytes are as follows. Byte 0 is 0xD1: board-kind bits [7:6]=11, bit 5=0 (not added to free memory), bit 4=1 (ROM vector valid), bit 3=0 (no chained board), bits [2:0]=001 (64 KB). Byte 1 is the product number, 0. Byte 2 holds the flags and is 0x00: bit 7=0 means no placement preference, and bit 6=0 means shut-up is supported. Bytes 4 and 5 hold the vendor number, 0x12 and 0x12. Bytes 6 to 9 hold the serial number, 0. Bytes 10 and 11 hold the ROM vector, 0x10 and 0x00. Every other byte is 0. Every byte except byte 0 is returned bitwise inverted.
- R4: A read at an odd offset below 0x80 gives `id_valid`=0 and `rdata`=0. It still counts as a slot hit.
- R5: A write to offset 0x4A in the configuration slot stores `bus_wdata[7:4]` as the pending low nibble. A repeated write overwrites the stored nibble. The card stays unconfigured.
- R6: A write to offset 0x48 in the configuration slot sets the slot to {`bus_wdata[7:4]`, pending nibble}. `configured` is 1 after that edge.
- R7: Once configured, the card answers only in its assigned slot. It makes no identity reads there, and further writes to 0x48 or 0x4A in that slot do not move it.
- R8: A read or write that falls in the card's current slot sets `slot_hit`=1 one clock later, and `local_off` then shows the 16-bit offset. This applies at every offset, in the configuration slot and in the assigned slot alike. When there is no hit, both outputs are 0.
- R9: A write to offset 0x4C in the configuration slot makes the card silent. From the next access on, `slot_hit` and `id_valid` stay 0 and `configured` stays 0 until reset.
- R10: Reset returns a configured or silenced card to the unconfigured state and clears the pending nibble. A commit with no prior 0x4A write therefore yields a low nibble of 0.
- R11: An access to any slot other than the card's current one leaves every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 24 | Host address: 8-bit slot number, then a 16-bit offset |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data byte |
| rdata | output | 8 | Identity nibble in bits [7:4], zero otherwise |
| id_valid | output | 1 | `rdata` carries an identity nibble |
| slot_hit | output | 1 | The previous access fell in the card's slot |
| local_off | output | 16 | Offset of the access that hit |
| configured | output | 1 | Card has moved to its assigned slot |

## Verification
The identity area is swept at all 64 even and some odd offsets. This separates nibble selection, inversion of every byte but the first, and rejection of odd offsets. Local offsets above 0x80 and foreign slots are probed before and after placement, which shows that decoding follows the current slot only. The placement sequence is run three ways: with repeated 0x4A writes, with no 0x4A write after a reset, and with a 0x48 write after placement. These cases distinguish the use of the latest nibble, the clearing of the nibble by reset, and the ignoring of a second commit. A silencing write followed by reads and commits confirms that silence lasts until reset.

// File: rtl/xcard_pkg.sv
package xcard_pkg;
  localparam int SLOT_W = 8;
  localparam logic [7:0] OFS_SLOT_HI = 8'h48;
  localparam logic [7:0] OFS_SLOT_LO = 8'h4A;
  localparam logic [7:0] OFS_SILENCE = 8'h4C;
  typedef enum logic [1:0] {ST_UNCFG, ST_PLACED, ST_SILENT} xcard_state_e;
endpackage

// File: rtl/xcard_id_rom.sv
module xcard_id_rom #(
  parameter logic [15:0] VENDOR    = 16'h1212,
  parameter logic [7:0]  PRODUCT   = 8'd0,
  parameter logic [31:0] SERIAL    = 32'd0,
  parameter logic [15:0] ROM_VEC   = 16'h1000,
  parameter logic [2:0]  SIZE_CODE = 3'b001,
  parameter int          ID_BYTES  = 32,
  localparam int         IDX_W     = $clog2(ID_BYTES)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             lo_half,
  output logic [3:0]       nib
);
  localparam logic [7:0] TYPE_B = {2'b11, 1'b0, 1'b1, 1'b0, SIZE_CODE};
  localparam logic [7:0] FLAG_B = 8'h00;

  logic [7:0] raw;
  logic [7:0] shown;

  always_comb begin
    case (idx)
      IDX_W'(0):  raw = TYPE_B;
      IDX_W'(1):  raw = PRODUCT;
      IDX_W'(2):  raw = FLAG_B;
      IDX_W'(4):  raw = VENDOR[15:8];
      IDX_W'(5):  raw = VENDOR[7:0];
      IDX_W'(6):  raw = SERIAL[31:24];
      IDX_W'(7):  raw = SERIAL[23:16];
      IDX_W'(8):  raw = SERIAL[15:8];
      IDX_W'(9):  raw = SERIAL[7:0];
      IDX_W'(10): raw = ROM_VEC[15:8];
      IDX_W'(11): raw = ROM_VEC[7:0];
      default:    raw = 8'h00;
    endcase
    shown = (idx == '0) ? raw : ~raw;
    nib   = lo_half ? shown[3:0] : shown[7:4];
  end
endmodule

// File: rtl/xcard_cfg_fsm.sv
module xcard_cfg_fsm
  import xcard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_silence,
  input  logic [3:0]        wr_nib,
  output xcard_state_e      state,
  output logic [SLOT_W-1:0] slot
);
  logic [3:0] pend_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_UNCFG;
      pend_lo <= 4'h0;
      slot    <= '0;
    end else if (state == ST_UNCFG) begin
      if (wr_silence) begin
        state <= ST_SILENT;
      end else if (wr_hi) begin
        state <= ST_PLACED;
        slot  <= {wr_nib, pend_lo};
      end else if (wr_lo) begin
        pend_lo <= wr_nib;
      end
    end
  end

  p_silent_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SILENT) |=> (state == ST_SILENT));

  p_lo_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi && !wr_silence && state == ST_UNCFG) |=> (state == ST_UNCFG));

  p_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_silence && state == ST_UNCFG) |=>
      (state == ST_PLACED && slot[SLOT_W-1 -: 4] == $past(wr_nib)));

  p_placed_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PLACED) |=> (state == ST_PLACED && $stable(slot)));
endmodule

// File: rtl/xcard_autocfg.sv
module xcard_autocfg
  import xcard_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [7:0]  CFG_SLOT  = 8'hE8,
  parameter logic [15:0] VENDOR    = 16'h1212,
  parameter logic [7:0]  PRODUCT   = 8'd0,
  parameter logic [31:0] SERIAL    = 32'd0,
  parameter logic [15:0] ROM_VEC   = 16'h1000,
  parameter logic [2:0]  SIZE_CODE = 3'b001,
  parameter int          ID_BYTES  = 32,
  localparam int         OFF_W     = ADDR_W - SLOT_W,
  localparam int         IDX_W     = $clog2(ID_BYTES),
  localparam int         ID_TOP    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rdata,
  output logic              id_valid,
  output logic              slot_hit,
  output logic [OFF_W-1:0]  local_off,
  output logic              configured
);
  xcard_state_e      state;
  logic [SLOT_W-1:0] cur_slot;
  logic [SLOT_W-1:0] acc_slot;
  logic [OFF_W-1:0]  acc_off;
  logic              in_cfg, in_placed, hit, id_rd, low_off, cfg_wr;
  logic [3:0]        id_nib;

  assign acc_slot  = bus_addr[ADDR_W-1 -: SLOT_W];
  assign acc_off   = bus_addr[OFF_W-1:0];
  assign in_cfg    = (state == ST_UNCFG) && (acc_slot == CFG_SLOT);
  assign in_placed = (state == ST_PLACED) && (acc_slot == cur_slot);
  assign hit       = (bus_rd || bus_wr) && (in_cfg || in_placed);
  assign low_off   = (acc_off[OFF_W-1:8] == '0);
  assign id_rd     = bus_rd && !bus_wr && in_cfg &&
                     (acc_off[OFF_W-1:ID_TOP] == '0) && !acc_off[0];
  assign cfg_wr    = bus_wr && in_cfg && low_off;

  xcard_id_rom #(
    .VENDOR(VENDOR), .PRODUCT(PRODUCT), .SERIAL(SERIAL),
    .ROM_VEC(ROM_VEC), .SIZE_CODE(SIZE_CODE), .ID_BYTES(ID_BYTES)
  ) u_rom (
    .idx     (acc_off[ID_TOP-1:2]),
    .lo_half (acc_off[1]),
    .nib     (id_nib)
  );

  xcard_cfg_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_lo      (cfg_wr && acc_off[7:0] == OFS_SLOT_LO),
    .wr_hi      (cfg_wr && acc_off[7:0] == OFS_SLOT_HI),
    .wr_silence (cfg_wr && acc_off[7:0] == OFS_SILENCE),
    .wr_nib     (bus_wdata[7:4]),
    .state      (state),
    .slot       (cur_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_hit  <= 1'b0;
      local_off <= '0;
      id_valid  <= 1'b0;
      rdata     <= 8'h00;
    end else begin
      slot_hit  <= hit;
      local_off <= hit ? acc_off : '0;
      id_valid  <= id_rd;
      rdata     <= id_rd ? {id_nib, 4'h0} : 8'h00;
    end
  end

  assign configured = (state == ST_PLACED);

  p_id_needs_hit_r2: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> slot_hit);

  p_no_id_when_placed_r7: assert property (@(posedge clk) disable iff (rst)
    configured |-> !id_valid);

  p_silent_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SILENT && $past(state) == ST_SILENT) |-> (!slot_hit && !id_valid));

  p_off_zero_on_miss_r8: assert property (@(posedge clk) disable iff (rst)
    !slot_hit |-> (local_off == '0 && rdata == 8'h00));
endmodule

// File: tb/sim_xcard_autocfg.sv
module sim_xcard_autocfg;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CFGS = 8'hE8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata;
  logic        id_valid, slot_hit, configured;
  logic [15:0] local_off;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [7:0]  idb [32];
  int          m_state = 0;
  logic [3:0]  m_pend = 0;
  logic [7:0]  m_slot = 0;
  logic [7:0]  e_rdata = 0;
  logic        e_idv = 0, e_hit = 0;
  logic [15:0] e_off = 0;

  xcard_autocfg u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rdata(rdata), .id_valid(id_valid), .slot_hit(slot_hit),
    .local_off(local_off), .configured(configured)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < 32; i++) idb[i] = 8'h00;
    idb[0] = 8'hD1; idb[4] = 8'h12; idb[5] = 8'h12; idb[10] = 8'h10;
  end

  // reference model, one step per rising edge
  always @(posedge clk) begin
    logic [7:0] s; logic [15:0] o; logic ic, ip, any, rdv; logic [7:0] b;
    if (rst) begin
      m_state = 0; m_pend = 0; m_slot = 0;
      e_rdata <= 0; e_idv <= 0; e_hit <= 0; e_off <= 0;
    end else begin
      s = bus_addr[23:16]; o = bus_addr[15:0];
      ic = (m_state == 0) && (s == CFGS);
      ip = (m_state == 1) && (s == m_slot);
      any = (bus_rd || bus_wr) && (ic || ip);
      rdv = bus_rd && !bus_wr && ic && o < 16'h80 && !o[0];
      b = idb[o[6:2]];
      if (o[6:2] != 0) b = ~b;
      e_hit <= any; e_off <= any ? o : 16'h0; e_idv <= rdv;
      e_rdata <= rdv ? {(o[1] ? b[3:0] : b[7:4]), 4'h0} : 8'h00;
      if (bus_wr && ic) begin
        if (o == 16'h4C) m_state = 2;
        else if (o == 16'h48) begin m_state = 1; m_slot = {bus_wdata[7:4], m_pend}; end
        else if (o == 16'h4A) m_pend = bus_wdata[7:4];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      vectors++;
      if (rdata !== e_rdata || id_valid !== e_idv || slot_hit !== e_hit ||
          local_off !== e_off || configured !== (m_state == 1)) begin
        fails++;
        $display("FAIL %s: got rd=%h v=%b hit=%b off=%h cfg=%b exp rd=%h v=%b hit=%b off=%h cfg=%b",
                 cur_req, rdata, id_valid, slot_hit, local_off, configured,
                 e_rdata, e_idv, e_hit, e_off, (m_state == 1));
      end
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: got hung run exp completion");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  task automatic acc(input bit rd, input bit wr, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R2";
    for (int k = 0; k < 128; k += 2) begin
      cur_req = (k < 48) ? "R3" : "R2";
      acc(1, 0, {CFGS, 16'(k)}, 0);
    end
    cur_req = "R4";
    acc(1, 0, {CFGS, 16'h0001}, 0);
    acc(1, 0, {CFGS, 16'h0013}, 0);
    acc(1, 0, {CFGS, 16'h007F}, 0);
    cur_req = "R8";
    acc(1, 0, {CFGS, 16'h07FE}, 0);
    acc(0, 1, {CFGS, 16'h0800}, 8'h5A);
    acc(1, 0, {CFGS, 16'hFFFF}, 0);
    cur_req = "R11";
    acc(1, 0, 24'h120000, 0);
    acc(0, 1, 24'hE90048, 8'hF0);
    cur_req = "R5";
    acc(0, 1, {CFGS, 16'h004A}, 8'h30);
    acc(0, 1, {CFGS, 16'h004A}, 8'h50);
    acc(1, 0, {CFGS, 16'h0010}, 0);
    cur_req = "R6";
    acc(0, 1, {CFGS, 16'h0048}, 8'hA7);
    cur_req = "R7";
    acc(1, 0, {CFGS, 16'h0000}, 0);
    acc(1, 0, 24'hA50000, 0);
    acc(1, 0, 24'hA50010, 0);
    acc(0, 1, 24'hA50048, 8'h30);
    acc(0, 1, 24'hA5004A, 8'h60);
    acc(1, 0, 24'hA5FFFF, 0);
    acc(1, 0, 24'h350000, 0);
    cur_req = "R10";
    do_reset();
    acc(1, 0, {CFGS, 16'h0012}, 0);
    acc(0, 1, {CFGS, 16'h0048}, 8'h70);
    acc(1, 0, 24'h700100, 0);
    acc(1, 0, 24'h750100, 0);
    cur_req = "R9";
    do_reset();
    acc(0, 1, {CFGS, 16'h004C}, 8'h00);
    acc(1, 0, {CFGS, 16'h0000}, 0);
    acc(0, 1, {CFGS, 16'h0048}, 8'h90);
    acc(1, 0, 24'h900000, 0);
    acc(1, 0, 24'h000000, 0);
    cur_req = "R10";
    do_reset();
    acc(1, 0, {CFGS, 16'h0000}, 0);
    acc(1, 0, {CFGS, 16'h0016}, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule